// File: doc/BRIEF.md
# Banked Data Memory Address Generator

This block turns the 7-bit register field of an instruction into a 9-bit physical data-memory address. The memory is split into four banks of 128 locations, so two bank bits sit above the offset. The bank bits come from one of two places. In direct mode, two bank-select bits of the status register supply them. In indirect mode, the bank comes from an extra status bit together with the top bit of an 8-bit pointer register, and the offset comes from the low seven pointer bits. Indirect mode is chosen when the instruction names the indirect-access slot, which is offset 00h.

A fixed set of offsets is mirrored in every bank. These are the core registers: the indirect-access slot, the status register and the pointer register, among others. Any access that resolves to one of these offsets is folded onto its bank 0 copy, and a shared flag is raised. Because of this fold, switching banks never hides the status or pointer registers. An indirect access whose pointer resolves to the indirect-access slot itself is marked as a null access. The consumer must then return 00h on a read and drop any write.

By default, the outputs are registered with one clock of latency. A parameter can make the path purely combinational. The RAM array and the register contents are outside this block.

Top module: `bank_addr_gen`

## Requirements
- R1: While rst_n is low, and after its release until the first rising clock edge, addr_q, shared_q, indir_q and null_q are all 0.
- R2: When the operand field is not 00h and the operand is not a mirrored offset, addr_q = {rp1, rp0, opnd[6:0]} (bit 8 = rp1, bit 7 = rp0) and indir_q = 0.
- R3: When the operand field is 00h, indir_q = 1. Unless the resolved offset is mirrored, addr_q = {irp, ptr[7], ptr[6:0]} (bit 8 = irp, bit 7 = ptr[7]).
- R4: The mirrored offsets are 00h, 02h, 03h, 04h, 0Ah and 0Bh. In direct mode, an access to one of them gives addr_q = {2'b00, offset} with shared_q = 1. Every other offset gives shared_q = 0.
- R5: The same fold applies in indirect mode to the offset ptr[6:0], whatever the values of irp and ptr[7].
- R6: null_q = 1 exactly when indir_q = 1 and ptr[6:0] = 00h. addr_q is then 000h. A consumer seeing null_q returns 00h on a read and suppresses the write.
- R7: Each output reflects the inputs sampled at the previous rising clock edge. Between edges, the outputs hold steady.
- R8: rp1 and rp0 have no effect in indirect mode. irp and ptr have no effect in direct mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd | input | 7 | Register field of the instruction |
| rp1 | input | 1 | Upper direct bank-select bit |
| rp0 | input | 1 | Lower direct bank-select bit |
| irp | input | 1 | Upper indirect bank bit |
| ptr | input | 8 | Pointer register value |
| addr_q | output | 9 | Physical data-memory address |
| shared_q | output | 1 | Access hit a register mirrored in all banks |
| indir_q | output | 1 | Access used the pointer |
| null_q | output | 1 | Indirect access pointed at the indirect slot itself |

## Verification
The bench drives the status offset 03h in every bank, both directly and through pointers whose top bit and irp point at banks 1 to 3. A design that skipped the fold would emit 083h, 103h or 183h instead of 003h. The pointer value 80h with irp set must give a null access at 000h. A design that treated bit 7 as part of the offset, or that missed the self-reference, would emit 180h with null_q low. Toggling rp1 and rp0 during indirect accesses, and irp and ptr during direct accesses, exposes a bank mux wired to the wrong source. Sampling just before and just after each edge catches a stage that is missing or doubled.

// File: rtl/bag_pkg.sv
package bag_pkg;
   typedef enum logic {
      MODE_DIRECT   = 1'b0,
      MODE_INDIRECT = 1'b1
   } bag_mode_e;

   // offsets 00h, 02h, 03h, 04h, 0Ah, 0Bh are present in every bank
   localparam logic [127:0] BAG_MIRROR_DEFAULT = 128'h0000_0000_0000_0000_0000_0000_0000_0C1D;

   localparam int BAG_BANK_W = 2;
endpackage

// File: rtl/bag_mode_sel.sv
module bag_mode_sel
   import bag_pkg::*;
#(
   parameter int OFS_W     = 7,
   parameter int INDIR_OFS = 0
) (
   input  logic [OFS_W-1:0]      opnd,
   input  logic                  rp1,
   input  logic                  rp0,
   input  logic                  irp,
   input  logic [OFS_W:0]        ptr,
   output bag_mode_e             mode,
   output logic [BAG_BANK_W-1:0] bank,
   output logic [OFS_W-1:0]      ofs
);
   localparam logic [OFS_W-1:0] INDIR_SLOT = OFS_W'(INDIR_OFS);

   always_comb begin
      if (opnd == INDIR_SLOT) begin
         mode = MODE_INDIRECT;
         bank = {irp, ptr[OFS_W]};
         ofs  = ptr[OFS_W-1:0];
      end else begin
         mode = MODE_DIRECT;
         bank = {rp1, rp0};
         ofs  = opnd;
      end
   end
endmodule

// File: rtl/bag_mirror_fold.sv
module bag_mirror_fold
   import bag_pkg::*;
#(
   parameter int                      OFS_W       = 7,
   parameter int                      INDIR_OFS   = 0,
   parameter logic [(2**OFS_W)-1:0]   MIRROR_MASK = BAG_MIRROR_DEFAULT[(2**OFS_W)-1:0]
) (
   input  bag_mode_e                  mode,
   input  logic [BAG_BANK_W-1:0]      bank,
   input  logic [OFS_W-1:0]           ofs,
   output logic [OFS_W+BAG_BANK_W-1:0] addr,
   output logic                       shared,
   output logic                       null_acc
);
   localparam int               SLOTS      = 2**OFS_W;
   localparam logic [OFS_W-1:0] INDIR_SLOT = OFS_W'(INDIR_OFS);

   logic [SLOTS-1:0] hit_vec;

   // one comparator per mirrored slot, pruned at elaboration
   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      if (MIRROR_MASK[s]) begin : g_on
         assign hit_vec[s] = (ofs == OFS_W'(s));
      end else begin : g_off
         assign hit_vec[s] = 1'b0;
      end
   end

   always_comb begin
      shared   = |hit_vec;
      null_acc = (mode == MODE_INDIRECT) && (ofs == INDIR_SLOT);
      if (shared) addr = {{BAG_BANK_W{1'b0}}, ofs};
      else        addr = {bank, ofs};
   end
endmodule

// File: rtl/bag_out_stage.sv
module bag_out_stage #(
   parameter int W       = 12,
   parameter int OUT_REG = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (OUT_REG != 0) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end else begin : g_comb
      assign q = d;
   end
endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
   import bag_pkg::*;
#(
   parameter int                    OFS_W       = 7,
   parameter int                    INDIR_OFS   = 0,
   parameter logic [(2**OFS_W)-1:0] MIRROR_MASK = BAG_MIRROR_DEFAULT[(2**OFS_W)-1:0],
   parameter int                    OUT_REG     = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [OFS_W-1:0]            opnd,
   input  logic                        rp1,
   input  logic                        rp0,
   input  logic                        irp,
   input  logic [OFS_W:0]              ptr,
   output logic [OFS_W+BAG_BANK_W-1:0] addr_q,
   output logic                        shared_q,
   output logic                        indir_q,
   output logic                        null_q
);
   localparam int ADDR_W = OFS_W + BAG_BANK_W;
   localparam int PIPE_W = ADDR_W + 3;

   if (OFS_W < 2 || OFS_W > 10) begin : g_chk_w
      $error("bank_addr_gen: OFS_W must be 2..10");
   end
   if (INDIR_OFS < 0 || INDIR_OFS >= 2**OFS_W) begin : g_chk_ind
      $error("bank_addr_gen: INDIR_OFS outside the bank");
   end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_chk_reg
      $error("bank_addr_gen: OUT_REG must be 0 or 1");
   end

   bag_mode_e             mode;
   logic [BAG_BANK_W-1:0] bank;
   logic [OFS_W-1:0]      ofs;
   logic [ADDR_W-1:0]     addr_c;
   logic                  shared_c;
   logic                  null_c;
   logic [PIPE_W-1:0]     pipe_q;

   bag_mode_sel #(.OFS_W(OFS_W), .INDIR_OFS(INDIR_OFS)) u_sel (
      .opnd(opnd), .rp1(rp1), .rp0(rp0), .irp(irp), .ptr(ptr),
      .mode(mode), .bank(bank), .ofs(ofs)
   );

   bag_mirror_fold #(.OFS_W(OFS_W), .INDIR_OFS(INDIR_OFS), .MIRROR_MASK(MIRROR_MASK)) u_fold (
      .mode(mode), .bank(bank), .ofs(ofs),
      .addr(addr_c), .shared(shared_c), .null_acc(null_c)
   );

   bag_out_stage #(.W(PIPE_W), .OUT_REG(OUT_REG)) u_out (
      .clk(clk), .rst_n(rst_n),
      .d({null_c, (mode == MODE_INDIRECT), shared_c, addr_c}),
      .q(pipe_q)
   );

   assign addr_q   = pipe_q[ADDR_W-1:0];
   assign shared_q = pipe_q[ADDR_W];
   assign indir_q  = pipe_q[ADDR_W+1];
   assign null_q   = pipe_q[ADDR_W+2];

   if (OUT_REG != 0) begin : g_chk
      logic primed;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) primed <= 1'b0;
         else        primed <= 1'b1;
      end

      p_indir_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
         primed |-> (indir_q == ($past(opnd) == OFS_W'(INDIR_OFS))));

      p_direct_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (primed && !indir_q && !shared_q) |-> (addr_q == {$past(rp1), $past(rp0), $past(opnd)}));

      p_indir_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (primed && indir_q && !shared_q) |-> (addr_q == {$past(irp), $past(ptr)}));

      p_fold_bank0_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (primed && shared_q) |-> (addr_q[ADDR_W-1 -: BAG_BANK_W] == '0));

      p_null_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (primed && null_q) |-> (indir_q && shared_q && addr_q == '0
                                 && $past(ptr[OFS_W-1:0]) == OFS_W'(INDIR_OFS)));

      p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (primed && $stable(opnd) && $stable(ptr) && $stable(irp) && $stable(rp1) && $stable(rp0)
          && $past(primed)) |=> $stable(addr_q));
   end
endmodule

// File: tb/bank_addr_gen_test.sv
module bank_addr_gen_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] opnd = '0;
   logic       rp1 = 1'b0, rp0 = 1'b0, irp = 1'b0;
   logic [7:0] ptr = '0;
   logic [8:0] addr_q;
   logic       shared_q, indir_q, null_q;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   bank_addr_gen uut (
      .clk(clk), .rst_n(rst_n), .opnd(opnd), .rp1(rp1), .rp0(rp0),
      .irp(irp), .ptr(ptr), .addr_q(addr_q), .shared_q(shared_q),
      .indir_q(indir_q), .null_q(null_q)
   );

   // expected {null, indir, shared, addr} from the requirements
   function automatic logic [11:0] model(input logic [6:0] o, input logic r1, input logic r0,
                                         input logic ip, input logic [7:0] p);
      logic [1:0] b;
      logic [6:0] f;
      logic       ind, sh, nl;
      logic [8:0] a;
      ind = (o == 7'h00);
      if (ind) begin b = {ip, p[7]}; f = p[6:0]; end
      else     begin b = {r1, r0};   f = o;      end
      sh = (f == 7'h00) || (f == 7'h02) || (f == 7'h03) || (f == 7'h04)
        || (f == 7'h0A) || (f == 7'h0B);
      nl = ind && (f == 7'h00);
      a  = sh ? {2'b00, f} : {b, f};
      return {nl, ind, sh, a};
   endfunction

   task automatic chk(input string req, input logic [11:0] got, input logic [11:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%03h expected=%03h", req, got, exp);
      end
   endtask

   function automatic logic [11:0] outs();
      return {null_q, indir_q, shared_q, addr_q};
   endfunction

   // drive at negedge, sample just after the next rising edge
   task automatic apply(input string req, input logic [6:0] o, input logic r1, input logic r0,
                        input logic ip, input logic [7:0] p);
      @(negedge clk);
      opnd = o; rp1 = r1; rp0 = r0; irp = ip; ptr = p;
      @(posedge clk); #1;
      chk(req, outs(), model(o, r1, r0, ip, p));
   endtask

   task automatic t_reset_r1();
      opnd = 7'h25; rp1 = 1; rp0 = 1; irp = 1; ptr = 8'hFF;
      repeat (3) @(posedge clk);
      #1 chk("R1 during reset", outs(), 12'h000);
      @(negedge clk) rst_n = 1'b1;
      #0.5 chk("R1 after release", outs(), 12'h000);
   endtask

   task automatic t_direct_r2();
      apply("R2 bank0", 7'h20, 0, 0, 1, 8'hFF);
      chk("R2 bank0 value", outs(), 12'h020);
      apply("R2 bank1", 7'h41, 0, 1, 0, 8'h00);
      apply("R2 bank2", 7'h20, 1, 0, 0, 8'h00);
      chk("R2 bank2 value", outs(), 12'h120);
      apply("R2 bank3 top", 7'h7F, 1, 1, 0, 8'h12);
      chk("R2 bank3 value", outs(), 12'h1FF);
      apply("R2 offset 05h", 7'h05, 1, 1, 0, 8'h00);
   endtask

   task automatic t_indirect_r3();
      apply("R3 ptr A5 irp1", 7'h00, 0, 0, 1, 8'hA5);
      chk("R3 value 1A5", outs(), 12'h5A5);
      apply("R3 ptr 25 irp0", 7'h00, 1, 1, 0, 8'h25);
      apply("R3 ptr FF irp0", 7'h00, 0, 0, 0, 8'hFF);
      apply("R3 ptr 7F irp1", 7'h00, 0, 0, 1, 8'h7F);
   endtask

   task automatic t_mirror_direct_r4();
      for (int b = 0; b < 4; b++) begin
         apply("R4 status each bank", 7'h03, b[1], b[0], 0, 8'h00);
         chk("R4 status folds to 003", outs(), 12'h203);
      end
      apply("R4 ptr reg bank3", 7'h04, 1, 1, 0, 8'h00);
      apply("R4 0Ah bank2", 7'h0A, 1, 0, 0, 8'h00);
      apply("R4 0Bh bank1", 7'h0B, 0, 1, 0, 8'h00);
      apply("R4 02h bank3", 7'h02, 1, 1, 0, 8'h00);
      apply("R4 01h not mirrored", 7'h01, 1, 1, 0, 8'h00);
      chk("R4 01h stays banked", outs(), 12'h181);
   endtask

   task automatic t_mirror_indirect_r5();
      apply("R5 ptr 83 irp1", 7'h00, 0, 0, 1, 8'h83);
      chk("R5 fold value", outs(), 12'h603);
      apply("R5 ptr 04 irp1", 7'h00, 1, 0, 1, 8'h04);
      apply("R5 ptr 8B irp0", 7'h00, 0, 0, 0, 8'h8B);
      apply("R5 ptr 8C not mirrored", 7'h00, 0, 0, 0, 8'h8C);
   endtask

   task automatic t_null_r6();
      apply("R6 ptr 80 irp1", 7'h00, 0, 0, 1, 8'h80);
      chk("R6 null value", outs(), 12'hE00);
      apply("R6 ptr 00 irp0", 7'h00, 1, 1, 0, 8'h00);
      apply("R6 direct 00 impossible, ptr 01", 7'h00, 0, 0, 0, 8'h01);
      chk("R6 no null for 01", outs(), 12'h401);
   endtask

   task automatic t_latency_r7();
      apply("R7 load", 7'h30, 0, 1, 0, 8'h00);
      @(negedge clk);
      opnd = 7'h31; rp1 = 1; rp0 = 0;
      #1 chk("R7 hold before edge", outs(), model(7'h30, 0, 1, 0, 8'h00));
      @(posedge clk); #1;
      chk("R7 update after edge", outs(), model(7'h31, 1, 0, 0, 8'h00));
   endtask

   task automatic t_ignore_r8();
      apply("R8 indirect rp 00", 7'h00, 0, 0, 0, 8'h9C);
      for (int b = 1; b < 4; b++) begin
         apply("R8 indirect rp varied", 7'h00, b[1], b[0], 0, 8'h9C);
         chk("R8 rp ignored", outs(), 12'h49C);
      end
      for (int k = 0; k < 4; k++) begin
         apply("R8 direct irp/ptr varied", 7'h55, 1, 0, k[0], 8'h80 + 8'(k * 17));
         chk("R8 irp/ptr ignored", outs(), 12'h155);
      end
   endtask

   initial begin
      t_reset_r1();
      t_direct_r2();
      t_indirect_r3();
      t_mirror_direct_r4();
      t_mirror_indirect_r5();
      t_null_r6();
      t_latency_r7();
      t_ignore_r8();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog expired got=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule